// File: doc/BRIEF.md
# Half-word routing register

A 32-bit datapath register that loads from a single shared bus word. Besides an ordinary full-word load, it can steer either 16-bit half of the bus into either 16-bit half of the register. The half it does not write keeps its old value. Fractions packed as two 16-bit fields can then be assembled piecewise, moved between halves or swapped, each in one bus cycle.

Four independent strobes each name one source half and one destination half. Strobes that write different destination halves may be combined in one cycle, and a combined pair acts as one load. Two strobes that aim at the same destination half are a control error. The register resolves the clash deterministically and flags it for one cycle.

Top module: `half_route_reg`

## Requirements
- R1: While rst_ni is low, q_o and conflict_o are zero.
- R2: With ld_full_i high at a rising clock edge, q_o equals bus_i after that edge.
- R3: ld_full_i overrides every half strobe active in the same cycle, and conflict_o stays low after that edge.
- R4: ld_hi2lo_i alone loads bus_i[31:16] into q_o[15:0] and leaves q_o[31:16] unchanged.
- R5: ld_lo2lo_i alone loads bus_i[15:0] into q_o[15:0] and leaves q_o[31:16] unchanged.
- R6: ld_lo2hi_i alone loads bus_i[15:0] into q_o[31:16] and leaves q_o[15:0] unchanged.
- R7: ld_hi2hi_i alone loads bus_i[31:16] into q_o[31:16] and leaves q_o[15:0] unchanged.
- R8: With no load input high, q_o holds its value.
- R9: ld_hi2lo_i with ld_lo2hi_i stores the bus with its halves swapped. ld_hi2hi_i with ld_lo2lo_i stores the bus unchanged.
- R10: ld_hi2lo_i with ld_lo2lo_i and no full load is a lower-half clash. The bus upper half is written to q_o[15:0], and conflict_o is high after that edge.
- R11: ld_hi2hi_i with ld_lo2hi_i and no full load is an upper-half clash. The bus upper half is written to q_o[31:16], and conflict_o is high after that edge.
- R12: conflict_o is low after any edge at which no clash of R10 or R11 was present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 32 | Bus word |
| ld_full_i | input | 1 | Load all 32 bits |
| ld_hi2lo_i | input | 1 | Bus upper half to register lower half |
| ld_lo2lo_i | input | 1 | Bus lower half to register lower half |
| ld_lo2hi_i | input | 1 | Bus lower half to register upper half |
| ld_hi2hi_i | input | 1 | Bus upper half to register upper half |
| q_o | output | 32 | Register contents |
| conflict_o | output | 1 | Clash on the previous edge |

## Verification
The hardest cases are those where a register half must be shown to be kept. A kept half is only visible when it differs from every bus half that could have been written into it. Before each strobe combination, the bench therefore full-loads a preset word whose four 16-bit values are all distinct from the bus halves that follow. It then sweeps all 32 combinations of the five load inputs over several bus patterns. One hold cycle after each combination shows that conflict_o drops again and that the register keeps its value.

// File: rtl/hwr_pkg.sv
package hwr_pkg;
  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned HALF_LO    = 0;
  localparam int unsigned HALF_HI    = 1;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_LO   = 2'd1,
    SRC_HI   = 2'd2
  } src_sel_e;
endpackage

// File: rtl/hwr_route_dec.sv
module hwr_route_dec
  import hwr_pkg::*;
(
  input  logic     ld_full_i,
  input  logic     ld_hi2lo_i,
  input  logic     ld_lo2lo_i,
  input  logic     ld_lo2hi_i,
  input  logic     ld_hi2hi_i,
  output src_sel_e sel_o   [NUM_HALVES],
  output logic     clash_o [NUM_HALVES]
);
  logic from_hi [NUM_HALVES];
  logic from_lo [NUM_HALVES];

  assign from_hi[HALF_LO] = ld_hi2lo_i;
  assign from_lo[HALF_LO] = ld_lo2lo_i;
  assign from_hi[HALF_HI] = ld_hi2hi_i;
  assign from_lo[HALF_HI] = ld_lo2hi_i;

  for (genvar d = 0; d < NUM_HALVES; d++) begin : g_dst
    localparam src_sel_e FULL_SRC = (d == HALF_HI) ? SRC_HI : SRC_LO;
    always_comb begin
      // upper-source strobe wins a clash
      if (ld_full_i)       sel_o[d] = FULL_SRC;
      else if (from_hi[d]) sel_o[d] = SRC_HI;
      else if (from_lo[d]) sel_o[d] = SRC_LO;
      else                 sel_o[d] = SRC_KEEP;
    end
    assign clash_o[d] = !ld_full_i && from_hi[d] && from_lo[d];
  end
endmodule

// File: rtl/hwr_half_reg.sv
module hwr_half_reg
  import hwr_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_sel_e          sel_i,
  input  logic [HALF_W-1:0] bus_lo_i,
  input  logic [HALF_W-1:0] bus_hi_i,
  output logic [HALF_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      unique case (sel_i)
        SRC_LO:  q_o <= bus_lo_i;
        SRC_HI:  q_o <= bus_hi_i;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/half_route_reg.sv
module half_route_reg
  import hwr_pkg::*;
#(
  parameter  int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = NUM_HALVES * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] bus_i,
  input  logic              ld_full_i,
  input  logic              ld_hi2lo_i,
  input  logic              ld_lo2lo_i,
  input  logic              ld_lo2hi_i,
  input  logic              ld_hi2hi_i,
  output logic [WORD_W-1:0] q_o,
  output logic              conflict_o
);
  src_sel_e sel   [NUM_HALVES];
  logic     clash [NUM_HALVES];
  logic     conflict_q;

  hwr_route_dec u_dec (
    .ld_full_i  (ld_full_i),
    .ld_hi2lo_i (ld_hi2lo_i),
    .ld_lo2lo_i (ld_lo2lo_i),
    .ld_lo2hi_i (ld_lo2hi_i),
    .ld_hi2hi_i (ld_hi2hi_i),
    .sel_o      (sel),
    .clash_o    (clash)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    hwr_half_reg #(.HALF_W(HALF_W)) u_half (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel[h]),
      .bus_lo_i (bus_i[HALF_LO*HALF_W +: HALF_W]),
      .bus_hi_i (bus_i[HALF_HI*HALF_W +: HALF_W]),
      .q_o      (q_o[h*HALF_W +: HALF_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conflict_q <= 1'b0;
    else         conflict_q <= clash[HALF_LO] | clash[HALF_HI];
  end

  assign conflict_o = conflict_q;
endmodule

// File: rtl/half_route_reg_chk.sv
module half_route_reg_chk #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned WORD_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] bus_i,
  input logic              ld_full_i,
  input logic              ld_hi2lo_i,
  input logic              ld_lo2lo_i,
  input logic              ld_lo2hi_i,
  input logic              ld_hi2hi_i,
  input logic [WORD_W-1:0] q_o,
  input logic              conflict_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic any_ld, clash_lo, clash_hi;
  assign any_ld   = ld_full_i | ld_hi2lo_i | ld_lo2lo_i | ld_lo2hi_i | ld_hi2hi_i;
  assign clash_lo = !ld_full_i && ld_hi2lo_i && ld_lo2lo_i;
  assign clash_hi = !ld_full_i && ld_hi2hi_i && ld_lo2hi_i;

  // R2
  full_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && ld_full_i |=> q_o == $past(bus_i));

  // R3
  full_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && ld_full_i |=> !conflict_o);

  // R4
  hi2lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !ld_full_i && ld_hi2lo_i && !ld_lo2lo_i && !ld_lo2hi_i && !ld_hi2hi_i
    |=> q_o == {$past(q_o[WORD_W-1:HALF_W]), $past(bus_i[WORD_W-1:HALF_W])});

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !any_ld |=> $stable(q_o));

  // R9
  swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !ld_full_i && ld_hi2lo_i && ld_lo2hi_i && !ld_lo2lo_i && !ld_hi2hi_i
    |=> q_o == {$past(bus_i[HALF_W-1:0]), $past(bus_i[WORD_W-1:HALF_W])});

  // R10
  clash_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && clash_lo |=> conflict_o && q_o[HALF_W-1:0] == $past(bus_i[WORD_W-1:HALF_W]));

  // R11
  clash_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && clash_hi |=> conflict_o && q_o[WORD_W-1:HALF_W] == $past(bus_i[WORD_W-1:HALF_W]));

  // R12
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !clash_lo && !clash_hi |=> !conflict_o);
endmodule

bind half_route_reg half_route_reg_chk #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_i      (bus_i),
  .ld_full_i  (ld_full_i),
  .ld_hi2lo_i (ld_hi2lo_i),
  .ld_lo2lo_i (ld_lo2lo_i),
  .ld_lo2hi_i (ld_lo2hi_i),
  .ld_hi2hi_i (ld_hi2hi_i),
  .q_o        (q_o),
  .conflict_o (conflict_o)
);

// File: tb/half_route_reg_tb.sv
module half_route_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] bus_i = '0;
  logic        ld_full_i = 1'b0, ld_hi2lo_i = 1'b0, ld_lo2lo_i = 1'b0;
  logic        ld_lo2hi_i = 1'b0, ld_hi2hi_i = 1'b0;
  logic [31:0] q_o;
  logic        conflict_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  half_route_reg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_i(bus_i),
    .ld_full_i(ld_full_i), .ld_hi2lo_i(ld_hi2lo_i), .ld_lo2lo_i(ld_lo2lo_i),
    .ld_lo2hi_i(ld_lo2hi_i), .ld_hi2hi_i(ld_hi2hi_i),
    .q_o(q_o), .conflict_o(conflict_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe bits: 4 full, 3 hi2hi, 2 lo2hi, 1 lo2lo, 0 hi2lo
  function automatic string tag_of(logic [4:0] s);
    if (s[4])                return (s[3:0] != 0) ? "R3" : "R2";
    if (s[0] && s[1])        return "R10";
    if (s[2] && s[3])        return "R11";
    if (s[0] && s[2])        return "R9";
    if (s[1] && s[3])        return "R9";
    if (s == 5'b00001)       return "R4";
    if (s == 5'b00010)       return "R5";
    if (s == 5'b00100)       return "R6";
    if (s == 5'b01000)       return "R7";
    if (s == 5'b00000)       return "R8";
    return "R4R7";
  endfunction

  task automatic drive(logic [4:0] s, logic [31:0] b);
    {ld_full_i, ld_hi2hi_i, ld_lo2hi_i, ld_lo2lo_i, ld_hi2lo_i} = s;
    bus_i = b;
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hA5A5_3C3C;
    pats[1] = 32'h0001_8000;
    pats[2] = 32'hFFFF_0000;
    pats[3] = 32'h1234_FEDC;

    @(negedge clk_i);
    // R1
    check("R1", q_o, 32'h0);
    check("R1", {31'h0, conflict_o}, 32'h0);
    drive(5'b10000, 32'hDEAD_BEEF);
    @(negedge clk_i);
    check("R1", q_o, 32'h0);
    rst_ni = 1'b1;

    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 32; c++) begin
        logic [4:0]  s;
        logic [31:0] b, pre, exp_q;
        logic [15:0] bh, bl;
        logic        exp_c;
        s = c[4:0];
        b = pats[p] ^ {c[7:0], 8'h00, c[7:0], 8'h00};
        pre = ~b ^ 32'h5A5A_A5A5;
        bh = b[31:16];
        bl = b[15:0];
        drive(5'b10000, pre);
        @(negedge clk_i);
        drive(s, b);
        @(negedge clk_i);
        exp_q = pre;
        if (s[4]) exp_q = b;
        else begin
          if (s[0])      exp_q[15:0]  = bh;
          else if (s[1]) exp_q[15:0]  = bl;
          if (s[3])      exp_q[31:16] = bh;
          else if (s[2]) exp_q[31:16] = bl;
        end
        exp_c = !s[4] && ((s[0] && s[1]) || (s[2] && s[3]));
        check(tag_of(s), q_o, exp_q);
        check(exp_c ? tag_of(s) : (s[4] ? "R3" : "R12"), {31'h0, conflict_o}, {31'h0, exp_c});
        drive(5'b00000, ~b);
        @(negedge clk_i);
        // R8 hold, R12 flag drops
        check("R8", q_o, exp_q);
        check("R12", {31'h0, conflict_o}, 32'h0);
      end
    end

    // R1 mid-run reset
    drive(5'b10000, 32'h7777_7777);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", q_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(5'b00000, '0);
    @(negedge clk_i);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule